// File: doc/BRIEF.md
# Write-Triggered FIFO Status Timer

This block produces the three activity flags of an expansion-bus bridge. Each host write through the bridge starts a fixed staggered sequence of pulses. The write-entry flag (bit 5) rises at once. The transfer flag (bit 4) rises after a lead time. The drain flag (bit 0) rises later still. Every pulse has its own on-deadline and off-deadline. These deadlines are compared against a free-running time base that advances one tick per clock.

A write that arrives while a pulse is already running lengthens that pulse and does not move its rising edge. This keeps the flags plausible under back-to-back writes. Software samples the flags through a read strobe. The sampled word holds until the next read.

Each pulse is handled by a four-state channel machine. The states are `CH_IDLE` (no deadline live), `CH_LEAD` (on-deadline and off-deadline live, flag low), `CH_HIGH` (only the off-deadline live, flag high) and `CH_HIGH_RELOAD` (flag high, a fresh on-deadline re-armed by a write, off-deadline live). The transitions are:
- on-reached: `CH_LEAD`→`CH_HIGH` and `CH_HIGH_RELOAD`→`CH_HIGH`.
- off-reached: any live state goes to `CH_IDLE`.
- arm on a write: `CH_IDLE`→`CH_LEAD`, or `CH_IDLE`→`CH_HIGH` for the channel with no lead.
- reload on a write: `CH_HIGH`→`CH_HIGH_RELOAD`.
- extend on a write: the state is kept and only the off-deadline moves.

Top module: `fst_status_timer`

## Requirements
- R1: After reset no deadline is live, a read returns 8'h00, and no flag rises later until a new write arrives.
- R2: After a lone write at tick W, bit 5 (mask 8'h20) reads 1 at ticks W through W+59 and reads 0 from W+60.
- R3: After a lone write at tick W, bit 4 (mask 8'h10) reads 1 from W+60 through W+219 and reads 0 otherwise.
- R4: After a lone write at tick W, bit 0 (mask 8'h01) reads 1 from W+120 through W+539 and reads 0 otherwise.
- R5: The bits of the 8-bit read word other than 5, 4 and 0 always read 0.
- R6: A write at a tick where a pulse's off-deadline is live and not yet reached moves that off-deadline later by the pulse length: 60 for bit 5, 160 for bit 4, 420 for bit 0.
- R7: A write at a tick where a pulse's on-deadline is live and not yet reached leaves that on-deadline, and so the rising edge, unchanged.
- R8: A write at a tick where a pulse's on-deadline is already consumed re-arms it at write tick + 60 (bit 4) or + 120 (bit 0). If that pulse's off-deadline is not live, the off-deadline becomes the new on-time plus the pulse length.
- R9: A deadline reached at the same tick as a write is applied before the write. The write's set of bit 5 wins over a clear of bit 5 at that tick.
- R10: A read strobe at tick t captures the flags with every deadline up to and including t applied, and with a write at t included. The captured word holds until the next read strobe.
- R11: A deadline is reached when (time base − deadline), taken modulo 2^TW, is non-negative as a signed value, so sequences that cross the wrap of the time base behave the same as any other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one time-base tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_now | input | TW (32) | Free-running time base value for this cycle |
| wr_stb | input | 1 | Host write through the bridge at this tick |
| rd_stb | input | 1 | Capture the status flags at this tick |
| rd_word | output | 8 | Last captured status word |

## Verification
The hardest case to reach from the ports is a write that lands on the exact tick where an earlier deadline is reached. Two such coincidences are exercised: bit 5 expiring while a new write sets it, and bit 4's off-deadline expiring while bit 0 is still mid-pulse. The bench reaches both by timing a second write at fixed offsets of 60 and 220 ticks after the first. It then reads at each edge tick and at the tick before it. The bench also starts the time base just below its wrap, so the first sequence's deadlines straddle zero.

// File: rtl/fst_pkg.sv
package fst_pkg;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_LEAD,
        CH_HIGH,
        CH_HIGH_RELOAD
    } ch_state_e;

    localparam int NUM_CH = 3;
    localparam int WORD_W = 8;

    // Status word bit positions are decoded by software: keep them fixed.
    localparam int POS_WR  = 5;
    localparam int POS_XF  = 4;
    localparam int POS_DR  = 0;

endpackage

// File: rtl/fst_reach.sv
module fst_reach #(
    parameter int TW = 32
) (
    input  logic          live_i,
    input  logic [TW-1:0] now_i,
    input  logic [TW-1:0] dl_i,
    output logic          hit_o
);
    logic [TW-1:0] gap;

    always_comb begin
        gap   = now_i - dl_i;
        hit_o = live_i && !gap[TW-1];
    end
endmodule

// File: rtl/fst_pulse_ch.sv
module fst_pulse_ch
    import fst_pkg::*;
#(
    parameter int TW   = 32,
    parameter int LEAD = 60,
    parameter int LEN  = 160
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] now_i,
    input  logic          wr_i,
    output logic          lvl_nxt_o
);
    localparam logic          IMMED  = (LEAD == 0);
    localparam logic [TW-1:0] LEAD_W = TW'(LEAD);
    localparam logic [TW-1:0] LEN_W  = TW'(LEN);

    ch_state_e     st_q, st_exp, st_d;
    logic [TW-1:0] on_dl_q, on_dl_d;
    logic [TW-1:0] off_dl_q, off_dl_d;
    logic          on_live, off_live;
    logic          on_hit, off_hit;
    logic          lvl_q;
    logic [TW-1:0] ord_gap;

    assign on_live  = (st_q == CH_LEAD) || (st_q == CH_HIGH_RELOAD);
    assign off_live = (st_q != CH_IDLE);
    assign lvl_q    = (st_q == CH_HIGH) || (st_q == CH_HIGH_RELOAD);
    assign ord_gap  = off_dl_q - on_dl_q;

    fst_reach #(.TW(TW)) u_on_cmp (
        .live_i(on_live), .now_i(now_i), .dl_i(on_dl_q), .hit_o(on_hit)
    );
    fst_reach #(.TW(TW)) u_off_cmp (
        .live_i(off_live), .now_i(now_i), .dl_i(off_dl_q), .hit_o(off_hit)
    );

    // Expiry first: deadlines reached at this tick are consumed.
    always_comb begin
        st_exp = st_q;
        unique case (st_q)
            CH_IDLE:        st_exp = CH_IDLE;
            CH_LEAD:        st_exp = on_hit ? (off_hit ? CH_IDLE : CH_HIGH) : CH_LEAD;
            CH_HIGH:        st_exp = off_hit ? CH_IDLE : CH_HIGH;
            CH_HIGH_RELOAD: st_exp = off_hit ? CH_IDLE : (on_hit ? CH_HIGH : CH_HIGH_RELOAD);
        endcase
    end

    // Then the write: arm, reload or extend.
    always_comb begin
        st_d     = st_exp;
        on_dl_d  = on_dl_q;
        off_dl_d = off_dl_q;
        if (wr_i) begin
            if (IMMED) begin
                st_d     = CH_HIGH;
                off_dl_d = (st_exp == CH_IDLE) ? now_i + LEN_W : off_dl_q + LEN_W;
            end else begin
                unique case (st_exp)
                    CH_IDLE: begin
                        st_d     = CH_LEAD;
                        on_dl_d  = now_i + LEAD_W;
                        off_dl_d = now_i + LEAD_W + LEN_W;
                    end
                    CH_LEAD: begin
                        off_dl_d = off_dl_q + LEN_W;
                    end
                    CH_HIGH: begin
                        st_d     = CH_HIGH_RELOAD;
                        on_dl_d  = now_i + LEAD_W;
                        off_dl_d = off_dl_q + LEN_W;
                    end
                    CH_HIGH_RELOAD: begin
                        off_dl_d = off_dl_q + LEN_W;
                    end
                endcase
            end
        end
    end

    // Output process: flag level after this tick's updates.
    always_comb begin
        lvl_nxt_o = (st_d == CH_HIGH) || (st_d == CH_HIGH_RELOAD);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= CH_IDLE;
            on_dl_q  <= '0;
            off_dl_q <= '0;
        end else begin
            st_q     <= st_d;
            on_dl_q  <= on_dl_d;
            off_dl_q <= off_dl_d;
        end
    end

    assert_off_extend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && off_live && !off_hit) |=> (off_dl_q == TW'($past(off_dl_q) + LEN_W)));

    assert_on_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && on_live && !on_hit) |=> (on_dl_q == $past(on_dl_q)));

    assert_off_after_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        on_live |-> (!ord_gap[TW-1] && (ord_gap != '0)));

    assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_q) |-> $past(wr_i || on_hit));

    assert_fall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lvl_q) |-> $past(off_hit));
endmodule

// File: rtl/fst_status_timer.sv
module fst_status_timer
    import fst_pkg::*;
#(
    parameter int TW      = 32,
    parameter int WR_LEN  = 60,
    parameter int XF_LEAD = 60,
    parameter int XF_LEN  = 160,
    parameter int DR_LEAD = 120,
    parameter int DR_LEN  = 420
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     tick_now,
    input  logic              wr_stb,
    input  logic              rd_stb,
    output logic [WORD_W-1:0] rd_word
);
    localparam int LEAD_A [NUM_CH] = '{0, XF_LEAD, DR_LEAD};
    localparam int LEN_A  [NUM_CH] = '{WR_LEN, XF_LEN, DR_LEN};
    localparam int POS_A  [NUM_CH] = '{POS_WR, POS_XF, POS_DR};
    localparam logic [WORD_W-1:0] USED_MASK =
        (WORD_W'(1) << POS_WR) | (WORD_W'(1) << POS_XF) | (WORD_W'(1) << POS_DR);

    logic [NUM_CH-1:0] lvl_nxt;
    logic [WORD_W-1:0] view;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        fst_pulse_ch #(
            .TW  (TW),
            .LEAD(LEAD_A[g]),
            .LEN (LEN_A[g])
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .now_i    (tick_now),
            .wr_i     (wr_stb),
            .lvl_nxt_o(lvl_nxt[g])
        );
    end

    always_comb begin
        view = '0;
        for (int i = 0; i < NUM_CH; i++) view[POS_A[i]] = lvl_nxt[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_word <= '0;
        else if (rd_stb) rd_word <= view;
    end

    assert_wr_sets_now_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && rd_stb) |=> rd_word[POS_WR]);

    assert_spare_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_word & ~USED_MASK) == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_stb) |-> $stable(rd_word));
endmodule

// File: tb/fst_status_timer_bench.sv
module fst_status_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tick_now = '0;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_word;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          reported = 0;
    logic [31:0] tnow = 32'hFFFF_FE00;   // starts below wrap (R11)

    always #4 clk = ~clk;

    fst_status_timer u_fst_status_timer (
        .clk(clk), .rst_n(rst_n), .tick_now(tick_now),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_word(rd_word)
    );

    // {scenario, second write offset (-1 none), read offset, expected}
    localparam int NV = 33;
    localparam int VEC [NV][4] = '{
        // lone write: R2 R3 R4, crossing the wrap (R11)
        '{0, -1,   0, 'h20}, '{0, -1,  59, 'h20}, '{0, -1,  60, 'h10},
        '{0, -1, 119, 'h10}, '{0, -1, 120, 'h11}, '{0, -1, 219, 'h11},
        '{0, -1, 220, 'h01}, '{0, -1, 539, 'h01}, '{0, -1, 540, 'h00},
        // back-to-back writes: R6 R7
        '{1,  1,  59, 'h20}, '{1,  1,  60, 'h30}, '{1,  1, 119, 'h30},
        '{1,  1, 120, 'h11}, '{1,  1, 379, 'h11}, '{1,  1, 380, 'h01},
        '{1,  1, 959, 'h01}, '{1,  1, 960, 'h00},
        // second write on bit 5 expiry tick: R9
        '{2, 60,  59, 'h20}, '{2, 60,  60, 'h30}, '{2, 60, 119, 'h30},
        '{2, 60, 120, 'h11}, '{2, 60, 379, 'h11}, '{2, 60, 380, 'h01},
        '{2, 60, 959, 'h01}, '{2, 60, 960, 'h00},
        // second write on bit 4 off tick: R8 R9
        '{3, 220, 219, 'h11}, '{3, 220, 220, 'h21}, '{3, 220, 279, 'h21},
        '{3, 220, 280, 'h11}, '{3, 220, 439, 'h11}, '{3, 220, 440, 'h01},
        '{3, 220, 959, 'h01}, '{3, 220, 960, 'h00}
    };
    localparam int VREQ [4] = '{2, 6, 9, 8};

    logic [31:0] wr_a, wr_b;
    bit          wr_b_on;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h at tick %08h", req, got, exp, tnow);
        end
    endtask

    task automatic step(input logic r);
        wr_stb   = (tnow == wr_a) || (wr_b_on && tnow == wr_b);
        rd_stb   = r;
        tick_now = tnow;
        @(posedge clk);
        @(negedge clk);
        tnow = tnow + 1;
        wr_stb = 1'b0;
        rd_stb = 1'b0;
    endtask

    task automatic go_read(input logic [31:0] target);
        while (tnow != target) step(1'b0);
        step(1'b1);
    endtask

    task automatic report;
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hung expected done");
        report();
    end

    initial begin
        logic [31:0] base;
        int          prev;
        wr_a = '1; wr_b = '1; wr_b_on = 0;
        @(negedge clk);
        step(1'b0); step(1'b0); step(1'b0);
        rst_n = 1'b1;
        step(1'b1);
        check("R1", rd_word, 8'h00);

        // vector table walk
        prev = -1;
        base = '0;
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][0] != prev) begin
                prev    = VEC[i][0];
                base    = tnow + 32'd5;
                wr_a    = base;
                wr_b_on = (VEC[i][1] >= 0);
                wr_b    = base + 32'(VEC[i][1]);
            end
            go_read(base + 32'(VEC[i][2]));
            check($sformatf("R%0d", VREQ[VEC[i][0]]), rd_word, 8'(VEC[i][3]));
            check("R5", rd_word & 8'hCE, 8'h00);
        end
        wr_b_on = 0;

        // R10: write and read in one tick, then hold without reading
        base = tnow + 32'd2;
        wr_a = base;
        go_read(base);
        check("R10", rd_word, 8'h20);
        while (tnow != base + 32'd101) step(1'b0);
        check("R10", rd_word, 8'h20);
        go_read(base + 32'd101);
        check("R3", rd_word, 8'h10);
        go_read(base + 32'd600);
        check("R4", rd_word, 8'h00);

        // R1: reset in mid-sequence clears every deadline
        base = tnow + 32'd2;
        wr_a = base;
        while (tnow != base + 32'd30) step(1'b0);
        rst_n = 1'b0;
        step(1'b0); step(1'b0);
        rst_n = 1'b1;
        go_read(base + 32'd70);
        check("R1", rd_word, 8'h00);
        go_read(base + 32'd130);
        check("R1", rd_word, 8'h00);
        go_read(base + 32'd600);
        check("R1", rd_word, 8'h00);

        report();
    end
endmodule